// File: doc/BRIEF.md
# Chainable Four-Bit Up/Down Counter

This block is a fully synchronous counter built from identical four-bit stages that share one rising-edge clock. Every stage has a two-bit select and an active-low carry input. The select chooses one of four operations: load the parallel data, count up, count down, or stop. The carry input only matters in the two count modes. When it is high, the stage keeps its value. When it is low, the stage takes its step.

Each stage drives an active-low carry output. That output goes low when the stage sits at its terminal value in the selected direction and its own carry input is low. It also goes low whenever the stage is in load mode. The carry output of one stage feeds the carry input of the next, with no gating between them. The carry is combinational, so it ripples from the least significant stage to the most significant one within one clock period, and the whole chain steps as one wide counter on a single edge.

The default wrapper chains three stages into a 12-bit counter. A synchronous reset clears the count so a test can start from a known state.

Top module: `sync_hex_chain`

The stage uses two named internal states, derived each cycle from the select and carry input:
- OP_LOAD: the stage takes in its data on the next edge.
- OP_INC: the stage counts up.
- OP_DEC: the stage counts down.
- OP_HOLD: the stage keeps its value.

The stage moves between these states as follows:
- load: any state goes to OP_LOAD when sel is 00.
- count: OP_INC is taken when sel is 01 and the stage carry input is low. OP_DEC is taken when sel is 10 and the stage carry input is low.
- stall: OP_HOLD is taken when sel is 11, or when sel is 01 or 10 with the stage carry input high.

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes 0 after that edge.
- R2: With `sel` = 2'b00, `q` takes the value of `din` on the next rising edge, whatever the level of `cy_in_n`.
- R3: With `sel` = 2'b01 and `cy_in_n` low, `q` increments by one on each rising edge and wraps from 12'hFFF to 12'h000.
- R4: With `sel` = 2'b10 and `cy_in_n` low, `q` decrements by one on each rising edge and wraps from 12'h000 to 12'hFFF.
- R5: With `sel` = 2'b01 or 2'b10 and `cy_in_n` high, `q` keeps its value.
- R6: With `sel` = 2'b11, `q` keeps its value whatever the level of `cy_in_n`.
- R7: `cy_out_n` is low, in the same cycle, whenever `sel` = 2'b00.
- R8: `cy_out_n` is low in the same cycle in two cases: `sel` = 2'b01, `cy_in_n` low and `q` = 12'hFFF; or `sel` = 2'b10, `cy_in_n` low and `q` = 12'h000. In every other count or stop situation it is high.
- R9: A carry between nibbles takes effect on the same edge as the step itself. Counting up from 12'h0FF gives 12'h100, and counting down from 12'h100 gives 12'h0FF, each in one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| sel | input | 2 | Operation select: 00 load, 01 up, 10 down, 11 stop |
| cy_in_n | input | 1 | Active-low count enable into the lowest stage; tie low for a free-running count |
| din | input | 12 | Parallel load value |
| q | output | 12 | Current count |
| cy_out_n | output | 1 | Active-low carry out of the highest stage |

## Verification
The count `q` is registered, so the result of an operation applied in one cycle appears one rising edge later. The carry output is combinational, so it is due in the same cycle as the inputs and the count that produce it. The driver sets the inputs on the falling edge and checks `cy_out_n` a nanosecond later. It then queues the expected count, and the monitor compares that count just after the next rising edge. Scenarios aim at the wrap points in both directions and at the carries between nibbles, and ignored carry inputs are proven by reading `q` on the edge that follows.

// File: rtl/hex_cnt_pkg.sv
package hex_cnt_pkg;

    // Select encoding seen at the stage boundary
    typedef enum logic [1:0] {
        SEL_LOAD = 2'b00,
        SEL_UP   = 2'b01,
        SEL_DOWN = 2'b10,
        SEL_STOP = 2'b11
    } sel_e;

    // Operation a stage performs on the coming edge
    typedef enum logic [1:0] {
        OP_LOAD,
        OP_INC,
        OP_DEC,
        OP_HOLD
    } op_e;

endpackage

// File: rtl/hex_op_decode.sv
module hex_op_decode
    import hex_cnt_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       cin_n,
    output op_e        op
);

    always_comb begin
        unique case (sel)
            SEL_LOAD: op = OP_LOAD;
            SEL_UP:   op = cin_n ? OP_HOLD : OP_INC;
            SEL_DOWN: op = cin_n ? OP_HOLD : OP_DEC;
            default:  op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/hex_nibble.sv
module hex_nibble
    import hex_cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  op_e          op,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         cout_n
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] q_r;
    logic [W-1:0] q_nx;

    // next-value logic
    always_comb begin
        unique case (op)
            OP_LOAD: q_nx = din;
            OP_INC:  q_nx = q_r + ONE;
            OP_DEC:  q_nx = q_r - ONE;
            default: q_nx = q_r;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= q_nx;
    end

    // outputs
    always_comb begin
        q = q_r;
        unique case (op)
            OP_LOAD: cout_n = 1'b0;
            OP_INC:  cout_n = (q_r != ALL_ONES);
            OP_DEC:  cout_n = (q_r != '0);
            default: cout_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/sync_hex_chain.sv
module sync_hex_chain
    import hex_cnt_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int STAGES = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                sel,
    input  logic                      cy_in_n,
    input  logic [NIB_W*STAGES-1:0]   din,
    output logic [NIB_W*STAGES-1:0]   q,
    output logic                      cy_out_n
);

    localparam int TOT_W = NIB_W * STAGES;

    logic [STAGES:0] carry_n;
    op_e             stage_op [STAGES];

    assign carry_n[0] = cy_in_n;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        hex_op_decode u_dec (
            .sel   (sel),
            .cin_n (carry_n[k]),
            .op    (stage_op[k])
        );

        hex_nibble #(.W(NIB_W)) u_nib (
            .clk    (clk),
            .rst    (rst),
            .op     (stage_op[k]),
            .din    (din[k*NIB_W +: NIB_W]),
            .q      (q[k*NIB_W +: NIB_W]),
            .cout_n (carry_n[k+1])
        );
    end

    assign cy_out_n = carry_n[STAGES];

endmodule

// File: rtl/sync_hex_chain_chk.sv
module sync_hex_chain_chk #(
    parameter int TOT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       sel,
    input logic             cy_in_n,
    input logic [TOT_W-1:0] din,
    input logic [TOT_W-1:0] q,
    input logic             cy_out_n
);

    localparam logic [TOT_W-1:0] ONE = {{(TOT_W-1){1'b0}}, 1'b1};

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (q == '0)); // R1

    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b00) |=> (q == $past(din))); // R2

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b01 && !cy_in_n) |=> (q == $past(q) + ONE)); // R3

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b10 && !cy_in_n) |=> (q == $past(q) - ONE)); // R4

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((sel == 2'b01 || sel == 2'b10) && cy_in_n) |=> $stable(q)); // R5

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b11) |=> $stable(q)); // R6

    AST_LOAD_CARRY: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b00) |-> !cy_out_n); // R7

    AST_UP_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b01 && !cy_in_n && q == '1) |-> !cy_out_n); // R8

    AST_DOWN_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b10 && !cy_in_n && q == '0) |-> !cy_out_n); // R8

    AST_STOP_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b11 || cy_in_n && sel != 2'b00) |-> cy_out_n); // R8

endmodule

bind sync_hex_chain sync_hex_chain_chk #(.TOT_W(NIB_W*STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .cy_in_n  (cy_in_n),
    .din      (din),
    .q        (q),
    .cy_out_n (cy_out_n)
);

// File: tb/test_sync_hex_chain.sv
module test_sync_hex_chain;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   sel = 2'b11;
    logic         cy_in_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic         cy_out_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] ref_q = '0;
    logic [W-1:0] exp_q_fifo [$];
    string        tag_fifo   [$];

    always #4 clk = ~clk;

    sync_hex_chain i_sync_hex_chain (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .cy_in_n  (cy_in_n),
        .din      (din),
        .q        (q),
        .cy_out_n (cy_out_n)
    );

    task automatic check_val(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, checks carry now, queues the count due after the edge
    task automatic step(input logic r, input logic [1:0] s, input logic ci, input logic [W-1:0] d, input string tag);
        logic exp_c;
        @(negedge clk);
        rst = r; sel = s; cy_in_n = ci; din = d;
        #1;
        if (!r) begin
            exp_c = !((s == 2'b00) ||
                      (s == 2'b01 && !ci && ref_q == '1) ||
                      (s == 2'b10 && !ci && ref_q == '0));
            check_val({tag, " carry R7/R8"}, {11'd0, cy_out_n}, {11'd0, exp_c});
        end
        if (r)                       ref_q = '0;
        else if (s == 2'b00)         ref_q = d;
        else if (s == 2'b01 && !ci)  ref_q = ref_q + 1'b1;
        else if (s == 2'b10 && !ci)  ref_q = ref_q - 1'b1;
        exp_q_fifo.push_back(ref_q);
        tag_fifo.push_back(tag);
    endtask

    // monitor: compares the count just after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q_fifo.size() > 0) begin
            string t;
            logic [W-1:0] e;
            e = exp_q_fifo.pop_front();
            t = tag_fifo.pop_front();
            check_val({t, " count"}, q, e);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        step(1, 2'b11, 1, 12'h5A5, "R1");
        step(1, 2'b00, 0, 12'h123, "R1");
        step(0, 2'b00, 1, 12'h0FE, "R2");        // load with carry-in high
        step(0, 2'b01, 0, 12'h000, "R3");        // 0FF
        step(0, 2'b01, 0, 12'h000, "R9");        // 100 in one edge
        step(0, 2'b01, 0, 12'h000, "R3");        // 101
        step(0, 2'b01, 1, 12'h000, "R5");        // gated hold
        step(0, 2'b10, 1, 12'h000, "R5");
        step(0, 2'b00, 0, 12'h100, "R2");        // load with carry-in low
        step(0, 2'b10, 0, 12'h000, "R9");        // 0FF in one edge
        step(0, 2'b10, 0, 12'h000, "R4");        // 0FE
        step(0, 2'b11, 0, 12'hABC, "R6");
        step(0, 2'b11, 1, 12'hABC, "R6");
        step(0, 2'b00, 0, 12'hFFE, "R2");
        step(0, 2'b01, 0, 12'h000, "R3");        // FFF
        step(0, 2'b01, 0, 12'h000, "R8");        // carry low at FFF, wraps to 000
        step(0, 2'b10, 0, 12'h000, "R8");        // carry low at 000, wraps to FFF
        step(0, 2'b01, 1, 12'h000, "R8");        // FFF but gated: carry high
        step(0, 2'b00, 1, 12'h001, "R7");
        step(0, 2'b10, 0, 12'h000, "R4");        // 000
        step(0, 2'b10, 0, 12'h000, "R4");        // FFF
        step(0, 2'b11, 0, 12'h000, "R8");        // stop at FFF: carry high
        for (int i = 0; i < 40; i++) step(0, 2'b01, 0, 12'h000, "R3");
        for (int i = 0; i < 60; i++) step(0, 2'b10, 0, 12'h000, "R4");
        for (int i = 0; i < 300; i++)
            step(0, 2'($urandom), 1'($urandom), 12'($urandom), "R2/R3/R4/R5/R6");
        step(1, 2'b01, 0, 12'h000, "R1");
        step(0, 2'b11, 0, 12'h000, "R6");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule